// File: doc/BRIEF.md
# Time-of-Day Counter with Scanned Four-Digit Display

The block counts the time of day from a single clock. A prescaler divides the clock down to a one-second tick. The tick drives a seconds counter, which carries into a minutes counter, which carries into an hours counter. When the hours roll over at midnight, a new-day flag pulses.

Minutes and seconds are each split into a tens digit and a units digit. The four resulting digits are shown one at a time on a single shared active-low segment bus. A free-running scan counter picks the digit, and a one-hot active-low enable marks which digit position is lit. The raw binary hour count and the new-day pulse are also brought out, so other logic can use them.

A parameter sets the number of clock cycles per second. A second parameter sets the width of the scan counter, which fixes how fast the display refreshes.

Top module: `timekeeper_display`

## Requirements
- R1: A synchronous reset, sampled high at a rising edge, clears the prescaler, seconds, minutes, hours and scan counter to zero. After reset the display shows zero in every slot, hour is 0 and new_day is 0.
- R2: The seconds count advances by one on every TICK_CYCLES-th rising edge after reset, and at no other edge.
- R3: A tick while seconds are 59 returns seconds to 0 and advances minutes on the same edge.
- R4: A tick while seconds and minutes are both 59 returns minutes to 0 and advances the hour output on the same edge.
- R5: The hours count runs from 0 to 23. A carry at 23 returns it to 0, and new_day is high for exactly the one cycle after that edge.
- R6: The top two bits of the SCAN_W-bit scan counter choose the slot. The counter increments on every clock. Values 0, 1, 2 and 3 drive digit_en_n to 1110, 1101, 1011 and 0111.
- R7: Slot 0 shows the seconds units digit, slot 1 the seconds tens digit, slot 2 the minutes units digit and slot 3 the minutes tens digit. Tens and units are split by decade ranges.
- R8: seg_n is active low, ordered {g,f,e,d,c,b,a}. Digits 0 to 9 are encoded as 1000000, 1111001, 0100100, 0110000, 0011001, 0010010, 0000010, 1111000, 0000000 and 0010000.
- R9: dp_n is held high (off) in every slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Single clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| seg_n | output | 7 | Active-low segments {g,f,e,d,c,b,a} for the digit now lit |
| dp_n | output | 1 | Active-low decimal point, always off |
| digit_en_n | output | 4 | One-hot active-low digit enable |
| hour | output | 5 | Binary hour count, 0 to 23 |
| new_day | output | 1 | One-cycle pulse after the midnight rollover |

## Verification
A corrupted prescaler or seconds register shows up on the segment bus the next time slot 0 or slot 1 is scanned. That is at most one scan period later, so the bench uses a short scan counter to keep this gap to a few cycles. A wrong carry into minutes appears within one scan period after the faulty edge. A wrong carry into hours appears at once on the hour port. A missing, early or doubled midnight pulse is caught on the very cycle it happens, because the bench runs a full day against its behavioural model and compares every cycle.

// File: rtl/timekeeper_display.sv
module timekeeper_display #(
  parameter int TICK_CYCLES = 5_000_000,
  parameter int SCAN_W      = 18
) (
  input  logic       clk,
  input  logic       rst,
  output logic [6:0] seg_n,
  output logic       dp_n,
  output logic [3:0] digit_en_n,
  output logic [4:0] hour,
  output logic       new_day
);
  localparam int PRE_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]  pre_q, pre_d;
  logic [5:0]        sec_q, sec_d, min_q, min_d;
  logic [4:0]        hr_q, hr_d;
  logic [SCAN_W-1:0] scan_q;
  logic              day_d;
  logic              tick, sec_wrap, min_wrap, hr_wrap;

  assign tick     = (pre_q == PRE_LAST);
  assign sec_wrap = tick && (sec_q == 6'd59);
  assign min_wrap = sec_wrap && (min_q == 6'd59);
  assign hr_wrap  = min_wrap && (hr_q == 5'd23);

  always_comb begin
    pre_d = pre_q + 1'b1;
    sec_d = sec_q;
    min_d = min_q;
    hr_d  = hr_q;
    day_d = 1'b0;
    if (tick) begin
      pre_d = '0;
      sec_d = sec_wrap ? 6'd0 : sec_q + 6'd1;
    end
    if (sec_wrap) min_d = min_wrap ? 6'd0 : min_q + 6'd1;
    if (min_wrap) hr_d  = hr_wrap ? 5'd0 : hr_q + 5'd1;
    if (hr_wrap)  day_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q   <= '0;
      sec_q   <= '0;
      min_q   <= '0;
      hr_q    <= '0;
      scan_q  <= '0;
      new_day <= 1'b0;
    end else begin
      pre_q   <= pre_d;
      sec_q   <= sec_d;
      min_q   <= min_d;
      hr_q    <= hr_d;
      scan_q  <= scan_q + 1'b1;
      new_day <= day_d;
    end
  end

  function automatic logic [7:0] split_dec(input logic [5:0] v);
    logic [5:0] u;
    logic [3:0] t;
    if (v < 6'd10)      begin t = 4'd0; u = v;         end
    else if (v < 6'd20) begin t = 4'd1; u = v - 6'd10; end
    else if (v < 6'd30) begin t = 4'd2; u = v - 6'd20; end
    else if (v < 6'd40) begin t = 4'd3; u = v - 6'd30; end
    else if (v < 6'd50) begin t = 4'd4; u = v - 6'd40; end
    else                begin t = 4'd5; u = v - 6'd50; end
    return {t, u[3:0]};
  endfunction

  function automatic logic [6:0] seg_code(input logic [3:0] d);
    case (d)
      4'd0:    return 7'b1000000;
      4'd1:    return 7'b1111001;
      4'd2:    return 7'b0100100;
      4'd3:    return 7'b0110000;
      4'd4:    return 7'b0011001;
      4'd5:    return 7'b0010010;
      4'd6:    return 7'b0000010;
      4'd7:    return 7'b1111000;
      4'd8:    return 7'b0000000;
      4'd9:    return 7'b0010000;
      default: return 7'b0111111;
    endcase
  endfunction

  logic [7:0] sec_dig, min_dig;
  logic [3:0] shown;
  assign sec_dig = split_dec(sec_q);
  assign min_dig = split_dec(min_q);

  always_comb begin
    shown      = sec_dig[3:0];
    digit_en_n = 4'b1110;
    case (scan_q[SCAN_W-1 -: 2])
      2'd0: begin shown = sec_dig[3:0]; digit_en_n = 4'b1110; end
      2'd1: begin shown = sec_dig[7:4]; digit_en_n = 4'b1101; end
      2'd2: begin shown = min_dig[3:0]; digit_en_n = 4'b1011; end
      2'd3: begin shown = min_dig[7:4]; digit_en_n = 4'b0111; end
      default: ;
    endcase
  end

  assign seg_n = seg_code(shown);
  assign dp_n  = 1'b1;
  assign hour  = hr_q;

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sec_q));
  // R3
  min_carry_chk: assert property (@(posedge clk) disable iff (rst)
    (tick && sec_q == 6'd59 && min_q != 6'd59) |=> (sec_q == 6'd0 && min_q == $past(min_q) + 6'd1));
  // R5
  new_day_chk: assert property (@(posedge clk) disable iff (rst)
    new_day |-> (hr_q == 5'd0 && min_q == 6'd0 && sec_q == 6'd0 && !$past(new_day)));
  // R5
  hour_range_chk: assert property (@(posedge clk) disable iff (rst)
    hr_q < 5'd24);
  // R6
  enable_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $countones(~digit_en_n) == 1);
endmodule

// File: tb/timekeeper_display_tb_top.sv
module timekeeper_display_tb_top;
  localparam int TICK = 2;
  localparam int SW   = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [6:0] seg_n;
  logic dp_n, new_day;
  logic [3:0] digit_en_n;
  logic [4:0] hour;

  int checks = 0, errors = 0, day_pulses = 0;
  int m_pre = 0, m_sec = 0, m_min = 0, m_hr = 0, m_scan = 0, m_day = 0;

  always #10 clk = ~clk;

  timekeeper_display #(.TICK_CYCLES(TICK), .SCAN_W(SW)) dut_i (
    .clk(clk), .rst(rst), .seg_n(seg_n), .dp_n(dp_n),
    .digit_en_n(digit_en_n), .hour(hour), .new_day(new_day));

  function automatic logic [6:0] pattern(input int d);
    logic [6:0] p [10] = '{7'b1000000, 7'b1111001, 7'b0100100, 7'b0110000,
                           7'b0011001, 7'b0010010, 7'b0000010, 7'b1111000,
                           7'b0000000, 7'b0010000};
    return p[d];
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_sec = 0; m_min = 0; m_hr = 0; m_scan = 0; m_day = 0;
    end else begin
      m_day = 0;
      m_scan = (m_scan + 1) % (1 << SW);
      m_pre = m_pre + 1;
      if (m_pre == TICK) begin
        m_pre = 0;
        m_sec = m_sec + 1;
        if (m_sec == 60) begin
          m_sec = 0;
          m_min = m_min + 1;
          if (m_min == 60) begin
            m_min = 0;
            m_hr = m_hr + 1;
            if (m_hr == 24) begin m_hr = 0; m_day = 1; end
          end
        end
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      int sel, val;
      logic [3:0] en;
      sel = m_scan >> (SW - 2);
      case (sel)
        0: val = m_sec % 10;
        1: val = m_sec / 10;
        2: val = m_min % 10;
        default: val = m_min / 10;
      endcase
      en = ~(4'b0001 << sel);
      check("R2 R3 R7 R8 segments", seg_n, pattern(val));
      check("R6 enables", digit_en_n, en);
      check("R4 hour", hour, m_hr);
      check("R5 new_day", new_day, m_day);
      check("R9 dp", dp_n, 1);
      if (new_day) day_pulses++;
    end
  end

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 reset seg", seg_n, 7'b1000000);
        check("R1 reset hour", hour, 0);
        check("R1 reset new_day", new_day, 0);
        repeat (700) @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check("R1 mid-run reset hour", hour, 0);
        check("R1 mid-run reset seg", seg_n, 7'b1000000);
        repeat (24 * 3600 * TICK + 200) @(negedge clk);
        // R5
        check("R5 one pulse per day", day_pulses, 1);
        check("R5 hour after midnight", hour, 0);
      end
      begin
        repeat (199000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual 1 expected 0");
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule